// File: doc/BRIEF.md
# Programmable Power-Key Debounce Unit

This unit conditions two active-low push buttons for a power-management controller: a power key and a reset key. Each input passes through a two-flop synchronizer and then a filter. The filtered level changes only after the synchronized input has held a new value for one full debounce period. The period is programmed as an exponential code measured against a two-second ceiling. In hardware, that ceiling is the `TICKS_MAX` clock count.

Each filtered change becomes an event in a four-entry queue. Any non-empty queue raises a level interrupt. The host reads the oldest event and removes it by writing a clear bit. The event stream stays consistent:
- A release that follows an unreported press is preceded by a synthetic press.
- Each key ignores its input for one debounce period after every release.

A byte-wide register port gives access to:
- the revision and subtype identifiers,
- the filtered key status,
- the two pull-up enables,
- the debounce code,
- the event queue head.

Top module: `pwrkey_debounce_unit`

## Requirements
- R1: After reset:
  - `irq` is 0.
  - The status register (0x10) reads 0x00.
  - The pull register (0x70) reads 0x03, and both pull enables are 1.
  - The debounce register (0x71) reads the default code: 8 when `SUBTYPE` >= 4, 0 otherwise.
  - Address 0x01 returns `REVISION` and address 0x05 returns `SUBTYPE`.
- R2: The debounce period in cycles is `TICKS_MAX >> (MAXCODE - code)`, with a floor of 1 cycle. The filtered level follows the synchronized input only after that input has differed from it for a full period. Shorter pulses produce no event.
- R3: The code field is 4 bits wide when `SUBTYPE` >= 4 and 3 bits wide otherwise. Written bits above the field are dropped and read back as zero.
- R4: Status register 0x10 shows the filtered key levels, with 1 meaning pressed. With `GEN3_STATUS`=0, bit 0 is the power key and bit 1 is the reset key. With `GEN3_STATUS`=1, bit 7 is the power key and bit 6 is the reset key. Writes to 0x10 change nothing.
- R5: In pull register 0x70, bit 1 drives `pwr_pull_en` and bit 0 drives `rst_pull_en`.
- R6: Every filtered change is queued in order, oldest first. Reading 0x72 returns the head event:
  - bit 7 is 1 when the queue is non-empty,
  - bit 1 is the key (0 for power, 1 for reset),
  - bit 0 is 1 for a press and 0 for a release.
  
  An empty queue reads 0x00.
- R7: `irq` is high while the queue holds an event. Writing 0x72 with bit 0 set removes the head event. Writing 0x72 with bit 0 clear has no effect.
- R8: After a key's release is committed, that key's input is ignored for one debounce period. After that window, a new level must again hold for a full period.
- R9: A committed release whose last reported state was already released queues a press and then the release.
- R10: An event group of one or two entries is queued only if all of its entries fit; otherwise the whole group is dropped. A dropped group leaves the last reported state unchanged, but the status register still follows the filter.
- R11: When both keys commit in the same cycle, the power key goes first and the reset key commits one cycle later. Both events are queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_key_n | input | 1 | Power key, low when pressed |
| rst_key_n | input | 1 | Reset key, low when pressed |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Event-pending interrupt level |
| pwr_pull_en | output | 1 | Power-key pull-up enable |
| rst_pull_en | output | 1 | Reset-key pull-up enable |

## Verification
The embedded properties are checked on every cycle. They cover:
- The two filters never commit in the same cycle.
- A filter's level stays frozen during its lockout.
- The filtered level only ever moves to the synchronized input value.
- The queue never receives more entries than it has room for.
- The interrupt never drops without a clear write.

Only the bench scenarios can show the following:
- The actual debounce period for each code.
- Pulse rejection.
- The event encoding and ordering, including the power-first tie break.
- A press inside the lockout window is lost.
- A dropped press is followed by a synthetic press-then-release pair once space returns.

// File: rtl/pwrkey_pkg.sv
package pwrkey_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    typedef enum logic {
        KEY_PWR = 1'b0,
        KEY_RST = 1'b1
    } key_id_e;

    typedef struct packed {
        key_id_e key;
        logic    press;
    } key_evt_t;

    localparam logic [7:0] A_REVISION = 8'h01;
    localparam logic [7:0] A_SUBTYPE  = 8'h05;
    localparam logic [7:0] A_STATUS   = 8'h10;
    localparam logic [7:0] A_PULL     = 8'h70;
    localparam logic [7:0] A_DEBOUNCE = 8'h71;
    localparam logic [7:0] A_EVENT    = 8'h72;

    localparam int unsigned NEWER_SUBTYPE_MIN = 4;

    // newer variant widens the exponent field by one bit
    function automatic int unsigned code_width(input int unsigned subtype);
        return (subtype >= NEWER_SUBTYPE_MIN) ? 4 : 3;
    endfunction

    // code matching the 15.625 ms default request for each variant
    function automatic int unsigned default_code(input int unsigned subtype);
        return (subtype >= NEWER_SUBTYPE_MIN) ? 8 : 0;
    endfunction
endpackage

// File: rtl/pwrkey_filter.sv
module pwrkey_filter #(
    parameter int unsigned CNTW = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            key_n,
    input  logic [CNTW-1:0] period,
    input  logic            grant,
    output logic            level,
    output logic            stable,
    output logic            commit
);
    timeunit 1ns;
    timeprecision 1ps;

    logic            s1_q, s2_q, stable_q, lock_q;
    logic [CNTW-1:0] cnt_q;
    logic            cnt_done, want;

    assign cnt_done = ({1'b0, cnt_q} + {{CNTW{1'b0}}, 1'b1}) >= {1'b0, period};
    assign want     = (s2_q != stable_q);
    assign commit   = !lock_q && want && cnt_done && grant;
    assign level    = s2_q;
    assign stable   = stable_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q     <= 1'b0;
            s2_q     <= 1'b0;
            stable_q <= 1'b0;
            lock_q   <= 1'b0;
            cnt_q    <= '0;
        end else begin
            s1_q <= ~key_n;
            s2_q <= s1_q;
            if (lock_q) begin
                if (cnt_done) begin
                    lock_q <= 1'b0;
                    cnt_q  <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else if (want) begin
                if (commit) begin
                    stable_q <= s2_q;
                    cnt_q    <= '0;
                    lock_q   <= !s2_q;
                end else if (!cnt_done) begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                cnt_q <= '0;
            end
        end
    end

    // R8: the filtered level is frozen during the post-release window
    assert_lock_freeze_R8: assert property (@(posedge clk) disable iff (rst)
        lock_q |=> $stable(stable_q));

    // R2: the filtered level only moves to the synchronized input value
    assert_follow_sync_R2: assert property (@(posedge clk) disable iff (rst)
        $changed(stable_q) |-> (stable_q == $past(s2_q)));
endmodule

// File: rtl/pwrkey_evq.sv
module pwrkey_evq
    import pwrkey_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [1:0]                 push_n,
    input  key_evt_t                   ent_a,
    input  key_evt_t                   ent_b,
    input  logic                       pop,
    output key_evt_t                   head,
    output logic                       empty,
    output logic [$clog2(DEPTH):0]     count
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned PTRW = $clog2(DEPTH);
    localparam int unsigned QW   = PTRW + 1;

    key_evt_t        mem_q [DEPTH];
    logic [PTRW-1:0] wp_q, rp_q, wp_next;
    logic [QW-1:0]   cnt_q;
    logic            pop_eff;

    assign empty   = (cnt_q == '0);
    assign pop_eff = pop && !empty;
    assign head    = mem_q[rp_q];
    assign count   = cnt_q;
    assign wp_next = wp_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_n != 2'd0) mem_q[wp_q]    <= ent_a;
            if (push_n == 2'd2) mem_q[wp_next] <= ent_b;
            wp_q  <= wp_q + PTRW'(push_n);
            if (pop_eff) rp_q <= rp_q + 1'b1;
            cnt_q <= cnt_q + QW'(push_n) - QW'(pop_eff);
        end
    end

    // R10: the producer never pushes past the free space
    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
        (32'(cnt_q) + 32'(push_n)) <= DEPTH);

    // R6: occupancy stays inside the queue depth
    assert_count_bound_R6: assert property (@(posedge clk) disable iff (rst)
        32'(cnt_q) <= DEPTH);
endmodule

// File: rtl/pwrkey_debounce_unit.sv
module pwrkey_debounce_unit
    import pwrkey_pkg::*;
#(
    parameter int unsigned SUBTYPE     = 4,
    parameter int unsigned REVISION    = 1,
    parameter bit          GEN3_STATUS = 1'b0,
    parameter int unsigned TICKS_MAX   = 2048,
    parameter int unsigned EVQ_DEPTH   = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pwr_key_n,
    input  logic       rst_key_n,
    input  logic [7:0] reg_addr,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq,
    output logic       pwr_pull_en,
    output logic       rst_pull_en
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned CODEW    = code_width(SUBTYPE);
    localparam int unsigned MAXCODE  = (1 << CODEW) - 1;
    localparam int unsigned DEF_CODE = default_code(SUBTYPE);
    localparam int unsigned CNTW     = $clog2(TICKS_MAX + 1);
    localparam int unsigned QW       = $clog2(EVQ_DEPTH) + 1;

    logic [CODEW-1:0] code_q;
    logic [1:0]       pull_q;      // [1] power, [0] reset
    logic [1:0]       rep_q;       // last reported level per key_id_e
    logic [CNTW-1:0]  period_raw, period;
    logic [CODEW-1:0] shamt;

    logic lvl_pwr, lvl_rst, stb_pwr, stb_rst, cmt_pwr, cmt_rst;
    logic any_cmt, sel_lvl, synth, fits, pop;
    key_id_e          sel_key;
    logic [1:0]       need, push_n;
    logic [QW-1:0]    q_count, space;
    key_evt_t         ent_a, ent_b, head;
    logic             q_empty;
    logic [7:0]       status_byte;
    logic             unused_wbits;

    assign unused_wbits = ^reg_wdata[7:CODEW];

    // exponential period against the full-scale tick count
    always_comb begin
        shamt      = CODEW'(MAXCODE) - code_q;
        period_raw = CNTW'(TICKS_MAX) >> shamt;
        period     = (period_raw == '0) ? CNTW'(1) : period_raw;
    end

    pwrkey_filter #(.CNTW(CNTW)) i_filt_pwr (
        .clk(clk), .rst(rst), .key_n(pwr_key_n), .period(period),
        .grant(1'b1), .level(lvl_pwr), .stable(stb_pwr), .commit(cmt_pwr)
    );

    pwrkey_filter #(.CNTW(CNTW)) i_filt_rst (
        .clk(clk), .rst(rst), .key_n(rst_key_n), .period(period),
        .grant(!cmt_pwr), .level(lvl_rst), .stable(stb_rst), .commit(cmt_rst)
    );

    // event group builder: one committing key per cycle, power first
    always_comb begin
        any_cmt = cmt_pwr || cmt_rst;
        sel_key = cmt_pwr ? KEY_PWR : KEY_RST;
        sel_lvl = cmt_pwr ? lvl_pwr : lvl_rst;
        synth   = !sel_lvl && !rep_q[sel_key];
        need    = synth ? 2'd2 : 2'd1;
        space   = QW'(EVQ_DEPTH) - q_count;
        fits    = space >= QW'(need);
        push_n  = (any_cmt && fits) ? need : 2'd0;
        ent_a   = '{key: sel_key, press: synth ? 1'b1 : sel_lvl};
        ent_b   = '{key: sel_key, press: 1'b0};
    end

    assign pop = reg_wr && (reg_addr == A_EVENT) && reg_wdata[0];

    pwrkey_evq #(.DEPTH(EVQ_DEPTH)) i_evq (
        .clk(clk), .rst(rst), .push_n(push_n), .ent_a(ent_a), .ent_b(ent_b),
        .pop(pop), .head(head), .empty(q_empty), .count(q_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= CODEW'(DEF_CODE);
            pull_q <= 2'b11;
            rep_q  <= 2'b00;
        end else begin
            if (reg_wr && reg_addr == A_PULL)     pull_q <= reg_wdata[1:0];
            if (reg_wr && reg_addr == A_DEBOUNCE) code_q <= reg_wdata[CODEW-1:0];
            if (any_cmt && fits)                  rep_q[sel_key] <= sel_lvl;
        end
    end

    generate
        if (GEN3_STATUS) begin : g_status_hi
            assign status_byte = {stb_pwr, stb_rst, 6'b0};
        end else begin : g_status_lo
            assign status_byte = {6'b0, stb_rst, stb_pwr};
        end
    endgenerate

    always_comb begin
        case (reg_addr)
            A_REVISION: reg_rdata = 8'(REVISION);
            A_SUBTYPE:  reg_rdata = 8'(SUBTYPE);
            A_STATUS:   reg_rdata = status_byte;
            A_PULL:     reg_rdata = {6'b0, pull_q};
            A_DEBOUNCE: reg_rdata = 8'(code_q);
            A_EVENT:    reg_rdata = q_empty ? 8'h00 : {1'b1, 5'b0, head.key, head.press};
            default:    reg_rdata = 8'h00;
        endcase
    end

    assign irq         = !q_empty;
    assign pwr_pull_en = pull_q[1];
    assign rst_pull_en = pull_q[0];

    // R11: the two filters never commit together
    assert_one_commit_R11: assert property (@(posedge clk) disable iff (rst)
        !(cmt_pwr && cmt_rst));

    // R7: the interrupt level only falls after a clear write
    assert_irq_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (irq && !pop) |=> irq);
endmodule

// File: tb/test_pwrkey_debounce_unit.sv
module test_pwrkey_debounce_unit;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwr_key_n = 1'b1;
    logic       rst_key_n = 1'b1;
    logic [7:0] reg_addr  = 8'h00;
    logic       reg_wr    = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq, pwr_pull_en, rst_pull_en;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    pwrkey_debounce_unit i_pwrkey_debounce_unit (
        .clk(clk), .rst(rst), .pwr_key_n(pwr_key_n), .rst_key_n(rst_key_n),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq), .pwr_pull_en(pwr_pull_en),
        .rst_pull_en(rst_pull_en)
    );

    // stimulus table: debounce code, pulse width in cycles, event expected
    localparam int NV = 6;
    localparam int VCODE [NV] = '{8, 8, 9, 9, 6, 6};
    localparam int VWID  [NV] = '{10, 40, 20, 60, 2, 12};
    localparam int VEXP  [NV] = '{0, 1, 0, 1, 0, 1};

    function automatic int exp_period(input int code);
        int p;
        p = 2048 >> (15 - code);
        return (p < 1) ? 1 : p;
    endfunction

    task automatic chk(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_head(input string req, input int exp);
        logic [7:0] d;
        rd(8'h72, d);
        chk(req, d, exp);
    endtask

    task automatic pop_head();
        wr(8'h72, 8'h01);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        idle(3);
        rst = 1'b0;
        idle(2);

        // R1 reset state
        chk("R1 irq", irq, 0);
        rd(8'h10, d); chk("R1 status", d, 8'h00);
        rd(8'h70, d); chk("R1 pull", d, 8'h03);
        chk("R1 pull pins", {pwr_pull_en, rst_pull_en}, 2'b11);
        rd(8'h71, d); chk("R1 debounce code", d, 8'h08);
        rd(8'h01, d); chk("R1 revision", d, 8'h01);
        rd(8'h05, d); chk("R1 subtype", d, 8'h04);
        expect_head("R6 empty queue", 8'h00);

        // R2 table walk over codes and pulse widths
        for (int i = 0; i < NV; i++) begin
            int p;
            p = exp_period(VCODE[i]);
            wr(8'h71, 8'(VCODE[i]));
            pwr_key_n = 1'b0;
            idle(VWID[i]);
            pwr_key_n = 1'b1;
            idle(3 * p + 20);
            if (VEXP[i] != 0) begin
                expect_head("R2 press after full period", 8'h81);
                pop_head();
                expect_head("R2 release after full period", 8'h80);
                pop_head();
            end
            expect_head("R2 queue drained or short pulse ignored", 8'h00);
            chk("R2 irq low", irq, 0);
        end
        wr(8'h71, 8'h08);

        // R5 pull mapping
        wr(8'h70, 8'h02);
        chk("R5 pull pins", {pwr_pull_en, rst_pull_en}, 2'b10);
        rd(8'h70, d); chk("R5 pull readback", d, 8'h02);

        // R3 field width
        wr(8'h71, 8'hF9);
        rd(8'h71, d); chk("R3 code masked", d, 8'h09);
        wr(8'h71, 8'h08);

        // R4 status bits, R11 simultaneous commits, R6 ordering, R7 clear
        pwr_key_n = 1'b0;
        idle(30);
        rd(8'h10, d); chk("R4 power bit0", d, 8'h01);
        rst_key_n = 1'b0;
        idle(30);
        rd(8'h10, d); chk("R4 both bits", d, 8'h03);
        wr(8'h10, 8'h00);
        rd(8'h10, d); chk("R4 status write ignored", d, 8'h03);
        pwr_key_n = 1'b1;
        rst_key_n = 1'b1;
        idle(60);
        rd(8'h10, d); chk("R4 released", d, 8'h00);
        chk("R7 irq pending", irq, 1);
        wr(8'h72, 8'h00);
        chk("R7 irq kept after bit0 clear write", irq, 1);
        expect_head("R6 first event pwr press", 8'h81);
        pop_head();
        expect_head("R6 second event rst press", 8'h83);
        pop_head();
        expect_head("R11 pwr release first", 8'h80);
        pop_head();
        expect_head("R11 rst release second", 8'h82);
        pop_head();
        chk("R7 irq cleared", irq, 0);

        // R8 lockout after release
        pwr_key_n = 1'b0;
        idle(30);
        expect_head("R8 setup press", 8'h81);
        pop_head();
        pwr_key_n = 1'b1;
        for (int k = 0; k < 100 && !irq; k++) @(negedge clk);
        pwr_key_n = 1'b0;
        idle(24);
        pwr_key_n = 1'b1;
        idle(80);
        expect_head("R8 release queued", 8'h80);
        pop_head();
        expect_head("R8 press inside lockout ignored", 8'h00);
        pwr_key_n = 1'b0;
        idle(40);
        expect_head("R8 press after lockout", 8'h81);
        pop_head();
        pwr_key_n = 1'b1;
        idle(60);
        pop_head();
        expect_head("R8 cleanup", 8'h00);

        // R10 full queue drops a press, R9 synthetic press later
        pwr_key_n = 1'b0; idle(30); pwr_key_n = 1'b1; idle(50);
        rst_key_n = 1'b0; idle(30); rst_key_n = 1'b1; idle(50);
        pwr_key_n = 1'b0;
        idle(30);
        rd(8'h10, d); chk("R10 status follows filter", d, 8'h01);
        expect_head("R10 head unchanged when full", 8'h81);
        pop_head();
        pop_head();
        pwr_key_n = 1'b1;
        idle(50);
        expect_head("R10 rst press kept", 8'h83);
        pop_head();
        expect_head("R10 rst release kept", 8'h82);
        pop_head();
        expect_head("R9 synthetic press", 8'h81);
        pop_head();
        expect_head("R9 release after synthetic", 8'h80);
        pop_head();
        expect_head("R9 queue empty", 8'h00);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule